// File: doc/BRIEF.md
# Two-Winding Microstep Current Sequencer

This block sequences a two-phase bipolar stepper motor. It keeps an electrical position index. For each winding it produces a direction bit and a 4-bit current-level code that a downstream converter and current regulator turn into winding current. The level code is inverted: the all-ones code means no current and the all-zeros code means full scale. The two windings follow a sine and a cosine profile across the four quadrants of the electrical period.

The index always counts in 64ths of an electrical period. A mode input picks the stride taken on each step pulse:

- full-step: 16 index units per step, giving 4 positions per period;
- half-step: 8 units per step, giving 8 positions;
- microstep: 1 unit per step, giving 64 positions.

A direction input picks the sense of motion. The direction bits, the level codes and the index are all registered, so the direction bits and level codes always agree with the index shown beside them.

Top module: `microstep_seq`

## Requirements
- R1: A synchronous active-low reset sets the following, and it wins over a step pulse in the same cycle:
  - `pos_o` = 0;
  - both direction bits = 1;
  - both level codes = 4'b0111 (71.4 %).
- R2: Let a = (pos + 8) mod 64, q = a[5:4] and k = a[3:0].
  - Winding 1 level index is m1 = 16-k when q is odd, and m1 = k otherwise.
  - Winding 2 level index is m2 = 16-m1.
  - Each code is 0 when m >= 15, and 15-m otherwise.
  - Code 15 is zero current. Codes 14 down to 0 are 9.5, 19.1, 28.6, 38.1, 47.6, 55.6, 63.5, 71.4, 77.8, 82.5, 88.9, 92.1, 95.2, 98.4 and 100 % of full scale.
- R3: With q as in R2, `ph1_o` is 1 when q is 0 or 1, and `ph2_o` is 1 when q is 0 or 3. A direction bit of 1 means the winding current flows from output A to output B, and 0 means the reverse.
- R4: In microstep mode (`mode_i` = 2'b10), a step pulse moves `pos_o` by +1 when `dir_i` = 1 and by -1 when `dir_i` = 0, wrapping modulo 64.
- R5: In full-step mode (`mode_i` = 2'b00), a step pulse moves the index by 16 modulo 64. Each full-step position drives both windings at code 4'b0111.
- R6: In half-step mode (`mode_i` = 2'b01), a step pulse moves the index by 8 modulo 64. At positions 8, 24, 40 and 56, one winding carries code 4'b1111 and the other carries code 4'b0000.
- R7: If the index is not a multiple of the new mode's stride, the next step pulse realigns it:
  - a forward step goes to the next multiple above the index;
  - a backward step goes to the next multiple below the index;
  - changing the mode without a step pulse leaves every output unchanged.
- R8: A cycle without a step pulse leaves `pos_o` and all winding outputs unchanged. After a step pulse, the index and all winding outputs change together at the edge that samples the pulse.
- R9: `mode_i` = 2'b11 behaves as microstep mode.
- R10: At no time do both windings carry the zero-current code 4'b1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | Step strobe; each high cycle advances once |
| dir_i | input | 1 | 1 = forward, 0 = backward |
| mode_i | input | 2 | 00 full, 01 half, 10/11 microstep |
| pos_o | output | 6 | Electrical position index in 64ths of a period |
| ph1_o | output | 1 | Winding 1 current direction |
| lvl1_o | output | 4 | Winding 1 inverted level code |
| ph2_o | output | 1 | Winding 2 current direction |
| lvl2_o | output | 4 | Winding 2 inverted level code |

## Verification
The bench builds the block with its default 6-bit index, so the period has 64 positions. Because the period is this short, a complete forward microstep walk fits in the run, and every quadrant boundary and the wrap from 63 to 0 are checked against a model of the angle mapping. The short period also makes the misaligned cases easy to reach: a full-step move from index 49 and a half-step move from index 63 each wrap to 0, and a half-step move back from index 1 realigns down to 0.

// File: rtl/microstep_seq_pkg.sv
// Shared constants and the step-mode encoding for the microstep sequencer.
// Assumes a period of 2**POS_W index units with a quarter of 2**(POS_W-2).
package microstep_seq_pkg;
    localparam int POS_W = 6;

    typedef enum logic [1:0] {
        MODE_FULL  = 2'd0,
        MODE_HALF  = 2'd1,
        MODE_MICRO = 2'd2,
        MODE_ALT   = 2'd3
    } step_mode_e;
endpackage

// File: rtl/microstep_index.sv
// Position index register with a mode-dependent stride.
// Assumes the full stride is a quarter period and the half stride an eighth.
// A misaligned index snaps to the next aligned position in the step direction.
module microstep_index #(
    parameter int POS_W = microstep_seq_pkg::POS_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           step_i,
    input  logic                           dir_i,
    input  microstep_seq_pkg::step_mode_e  mode_i,
    output logic [POS_W-1:0]               pos_q,
    output logic [POS_W-1:0]               pos_d
);
    import microstep_seq_pkg::*;

    localparam logic [POS_W-1:0] FULL_MASK = POS_W'((1 << (POS_W - 2)) - 1);
    localparam logic [POS_W-1:0] HALF_MASK = POS_W'((1 << (POS_W - 3)) - 1);

    logic [POS_W-1:0] mask;
    logic [POS_W-1:0] stride;
    logic [POS_W-1:0] base;
    logic             aligned;
    logic [POS_W-1:0] moved;

    // Select the low-bit mask that defines valid positions for the mode.
    always_comb begin
        unique case (mode_i)
            MODE_FULL: mask = FULL_MASK;
            MODE_HALF: mask = HALF_MASK;
            default:   mask = '0;
        endcase
    end

    // Compute the target position of one step, realigning if needed.
    always_comb begin
        stride  = mask + POS_W'(1);
        base    = pos_q & ~mask;
        aligned = (pos_q & mask) == '0;
        if (dir_i) begin
            moved = base + stride;
        end else if (aligned) begin
            moved = pos_q - stride;
        end else begin
            moved = base;
        end
    end

    // Next index: reset to zero, step, or hold.
    always_comb begin
        if (!rst_n) begin
            pos_d = '0;
        end else if (step_i) begin
            pos_d = moved;
        end else begin
            pos_d = pos_q;
        end
    end

    // Hold the index.
    always_ff @(posedge clk) begin
        pos_q <= pos_d;
    end
endmodule

// File: rtl/microstep_winding_map.sv
// Maps an index to one winding's direction bit and inverted level code.
// The angle is shifted by an eighth period so that index 0 sits mid-quadrant.
// IS_COS selects the cosine winding; otherwise the sine winding is produced.
// Assumes the level code width equals log2 of the quarter period.
module microstep_winding_map #(
    parameter int POS_W  = microstep_seq_pkg::POS_W,
    parameter bit IS_COS = 1'b0
) (
    input  logic [POS_W-1:0] pos_i,
    output logic             ph_o,
    output logic [POS_W-3:0] lvl_o
);
    localparam int QTR_W = POS_W - 2;
    localparam logic [POS_W-1:0] SHIFT = POS_W'(1 << (QTR_W - 1));
    localparam logic [QTR_W:0]   QTR_V = (QTR_W + 1)'(1 << QTR_W);
    localparam logic [QTR_W:0]   LMAX  = QTR_V - (QTR_W + 1)'(1);

    logic [POS_W-1:0] ang;
    logic [1:0]       quad;
    logic [QTR_W:0]   k;
    logic [QTR_W:0]   m_sin;
    logic [QTR_W:0]   m;
    logic [QTR_W:0]   inv;

    // Derive quadrant and offset of the shifted angle.
    always_comb begin
        ang   = pos_i + SHIFT;
        quad  = ang[POS_W-1 -: 2];
        k     = {1'b0, ang[QTR_W-1:0]};
        m_sin = quad[0] ? (QTR_V - k) : k;
    end

    generate
        if (IS_COS) begin : g_cos
            // Cosine winding: complement of the sine magnitude, positive in quadrants 0 and 3.
            always_comb begin
                m    = QTR_V - m_sin;
                ph_o = (quad[1] == quad[0]);
            end
        end else begin : g_sin
            // Sine winding: positive in quadrants 0 and 1.
            always_comb begin
                m    = m_sin;
                ph_o = ~quad[1];
            end
        end
    endgenerate

    // Convert magnitude to the inverted level code, saturating at full scale.
    always_comb begin
        inv   = LMAX - m;
        lvl_o = (m >= LMAX) ? '0 : inv[QTR_W-1:0];
    end
endmodule

// File: rtl/microstep_seq.sv
// Top of the two-winding microstep sequencer.
// The index register and both winding codes load together from the next index,
// so the outputs never lag the index.
// Synchronous active-low reset.
module microstep_seq #(
    parameter int POS_W = microstep_seq_pkg::POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             dir_i,
    input  logic [1:0]       mode_i,
    output logic [POS_W-1:0] pos_o,
    output logic             ph1_o,
    output logic [POS_W-3:0] lvl1_o,
    output logic             ph2_o,
    output logic [POS_W-3:0] lvl2_o
);
    import microstep_seq_pkg::*;

    localparam int LVL_W = POS_W - 2;
    localparam int N_WND = 2;

    step_mode_e       mode;
    logic [POS_W-1:0] pos_d;
    logic             ph_d  [N_WND];
    logic [LVL_W-1:0] lvl_d [N_WND];
    logic             ph_q  [N_WND];
    logic [LVL_W-1:0] lvl_q [N_WND];

    // Cast the raw mode pins to the mode type.
    always_comb mode = step_mode_e'(mode_i);

    microstep_index #(.POS_W(POS_W)) u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_i),
        .dir_i  (dir_i),
        .mode_i (mode),
        .pos_q  (pos_o),
        .pos_d  (pos_d)
    );

    generate
        for (genvar w = 0; w < N_WND; w++) begin : g_wnd
            microstep_winding_map #(.POS_W(POS_W), .IS_COS(w == 1)) u_map (
                .pos_i (pos_d),
                .ph_o  (ph_d[w]),
                .lvl_o (lvl_d[w])
            );

            // Register this winding's drive outputs alongside the index.
            always_ff @(posedge clk) begin
                ph_q[w]  <= ph_d[w];
                lvl_q[w] <= lvl_d[w];
            end
        end
    endgenerate

    // Route the registered winding outputs to the ports.
    always_comb begin
        ph1_o  = ph_q[0];
        lvl1_o = lvl_q[0];
        ph2_o  = ph_q[1];
        lvl2_o = lvl_q[1];
    end
endmodule

// File: rtl/microstep_seq_chk.sv
// Checker for the microstep sequencer, bound to the top module.
// It observes only the top-level ports.
module microstep_seq_chk #(
    parameter int POS_W = microstep_seq_pkg::POS_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_i,
    input logic             dir_i,
    input logic [1:0]       mode_i,
    input logic [POS_W-1:0] pos_o,
    input logic             ph1_o,
    input logic [POS_W-3:0] lvl1_o,
    input logic             ph2_o,
    input logic [POS_W-3:0] lvl2_o
);
    localparam logic [POS_W-3:0] ZERO_CODE = '1;
    localparam logic [POS_W-3:0] DIAG_CODE = ZERO_CODE >> 1;

    // R8
    hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(pos_o) && $stable(ph1_o) && $stable(lvl1_o)
                     && $stable(ph2_o) && $stable(lvl2_o)));

    // R4
    micro_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && dir_i && mode_i == 2'b10) |=> pos_o == $past(pos_o) + POS_W'(1));

    // R5
    full_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mode_i == 2'b00) |=>
            (pos_o[POS_W-3:0] == '0 && lvl1_o == DIAG_CODE && lvl2_o == DIAG_CODE));

    // R6
    half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mode_i == 2'b01) |=> pos_o[POS_W-4:0] == '0);

    // R10
    never_both_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lvl1_o == ZERO_CODE && lvl2_o == ZERO_CODE));
endmodule

bind microstep_seq microstep_seq_chk #(.POS_W(POS_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step_i),
    .dir_i  (dir_i),
    .mode_i (mode_i),
    .pos_o  (pos_o),
    .ph1_o  (ph1_o),
    .lvl1_o (lvl1_o),
    .ph2_o  (ph2_o),
    .lvl2_o (lvl2_o)
);

// File: tb/microstep_seq_bench.sv
// Self-checking bench: vector table walk, then directed reset and corner tests.
module microstep_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_i = 1'b0;
    logic       dir_i = 1'b1;
    logic [1:0] mode_i = 2'b10;
    logic [5:0] pos_o;
    logic       ph1_o, ph2_o;
    logic [3:0] lvl1_o, lvl2_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    microstep_seq u_microstep_seq (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i), .mode_i(mode_i),
        .pos_o(pos_o), .ph1_o(ph1_o), .lvl1_o(lvl1_o), .ph2_o(ph2_o), .lvl2_o(lvl2_o)
    );

    always #10 clk = ~clk;

    // Vector fields: {step, dir, mode[1:0], expected pos[5:0]}
    localparam logic [9:0] VEC [18] = '{
        {1'b1, 1'b1, 2'd2, 6'd1},  {1'b1, 1'b1, 2'd2, 6'd2},
        {1'b1, 1'b0, 2'd2, 6'd1},  {1'b1, 1'b0, 2'd2, 6'd0},
        {1'b1, 1'b0, 2'd2, 6'd63}, {1'b1, 1'b1, 2'd1, 6'd0},
        {1'b1, 1'b1, 2'd1, 6'd8},  {1'b1, 1'b1, 2'd1, 6'd16},
        {1'b1, 1'b0, 2'd0, 6'd0},  {1'b1, 1'b0, 2'd0, 6'd48},
        {1'b0, 1'b1, 2'd2, 6'd48}, {1'b1, 1'b1, 2'd3, 6'd49},
        {1'b0, 1'b0, 2'd0, 6'd49}, {1'b1, 1'b1, 2'd0, 6'd0},
        {1'b1, 1'b1, 2'd2, 6'd1},  {1'b1, 1'b0, 2'd1, 6'd0},
        {1'b1, 1'b0, 2'd1, 6'd56}, {1'b1, 1'b0, 2'd1, 6'd48}
    };

    // Expected {ph1, lvl1, ph2, lvl2} for an index, from the R2/R3 mapping.
    function automatic logic [9:0] model(input int p);
        int a, q, k, m1, m2, c1, c2;
        logic e1, e2;
        a  = (p + 8) % 64;
        q  = a / 16;
        k  = a % 16;
        m1 = (q % 2 == 1) ? 16 - k : k;
        m2 = 16 - m1;
        c1 = (m1 >= 15) ? 0 : 15 - m1;
        c2 = (m2 >= 15) ? 0 : 15 - m2;
        e1 = (q < 2);
        e2 = (q == 0 || q == 3);
        return {e1, 4'(c1), e2, 4'(c2)};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input int exp_pos);
        check({tag, " pos"}, pos_o, exp_pos);
        check("R2 R3 winding outputs", {ph1_o, lvl1_o, ph2_o, lvl2_o}, model(exp_pos));
    endtask

    // Drive one cycle of stimulus at the falling edge; sample at the next falling edge.
    task automatic drive(input logic s, input logic d, input logic [1:0] m);
        step_i = s;
        dir_i  = d;
        mode_i = m;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: values loaded while reset is held, and after release.
        check("R1 pos", pos_o, 0);
        check("R1 phases", {ph1_o, ph2_o}, 2'b11);
        check("R1 lvl1", lvl1_o, 4'b0111);
        check("R1 lvl2", lvl2_o, 4'b0111);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 0);

        for (int i = 0; i < 18; i++) begin
            string tag;
            if (!VEC[i][9])                  tag = "R8";
            else if (VEC[i][7:6] == 2'd0)    tag = "R5";
            else if (VEC[i][7:6] == 2'd1)    tag = "R6";
            else if (VEC[i][7:6] == 2'd3)    tag = "R9";
            else                             tag = "R4";
            drive(VEC[i][9], VEC[i][8], VEC[i][7:6]);
            check_all(tag, int'(VEC[i][5:0]));
        end

        // R6: at 56 one winding is off and the other is full scale.
        drive(1'b1, 1'b1, 2'b01);
        check("R6 lvl1 at 56", lvl1_o, 4'b1111);
        check("R6 lvl2 at 56", lvl2_o, 4'b0000);

        // R7: realignment in both directions; a mode change alone holds.
        drive(1'b1, 1'b1, 2'b10);      // 57
        drive(1'b1, 1'b1, 2'b10);      // 58
        drive(1'b0, 1'b1, 2'b00);      // mode change only
        check_all("R7 hold", 58);
        drive(1'b1, 1'b0, 2'b00);
        check_all("R7 back to 48", 48);
        drive(1'b1, 1'b1, 2'b10);      // 49
        drive(1'b1, 1'b1, 2'b01);
        check_all("R7 fwd to 56", 56);

        // R2 R3 R4: full microstep walk forward from 0.
        drive(1'b1, 1'b1, 2'b01);      // 0
        check_all("R4", 0);
        for (int p = 1; p <= 64; p++) begin
            drive(1'b1, 1'b1, 2'b10);
            check_all("R4 walk", p % 64);
            if (lvl1_o == 4'hF && lvl2_o == 4'hF) check("R10 both off", 1, 0);
        end

        // R1: reset during a step pulse wins.
        drive(1'b1, 1'b0, 2'b10);      // 63
        rst_n = 1'b0;
        drive(1'b1, 1'b0, 2'b10);
        rst_n = 1'b1;
        check_all("R1 reset over step", 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule